// File: doc/BRIEF.md
# Packed Single-Precision Maximum Unit

This block takes two vectors of IEEE-754 single-precision values and returns, lane by lane, the larger of each pair. The result goes into one output register, so it appears one clock after the operands are presented. The rule for picking a lane is asymmetric. Whenever the outcome is not a strict "first operand is larger", the second operand wins. That covers a pair of zeros of either sign, any NaN in the pair, and equal values. A signaling NaN taken from the second operand passes through bit for bit.

Around the comparison sit the selections a vector register file needs. The active length can be 4, 8 or 16 lanes, and the bits above it are either cleared or kept from the old destination. A per-lane mask either merges in the old destination or zeroes the lane. The second operand can be replaced by its lowest 32-bit element copied to every lane. Comparison works directly on the sign-magnitude encoding. It raises no flags, and denormals are not flushed.

Top module: `fpmax_vec`

## Requirements
- R1: For a lane pair with no NaN and not both zero, the output lane equals `src_a` only when `src_a` is strictly greater in value, with a positive value above any negative value and, between two negatives, the larger magnitude the smaller value. Otherwise it equals the second operand.
- R2: When both lane inputs are zero (encoding with bits 30:0 all zero, either sign), the output lane is the second operand, including its sign bit.
- R3: When either or both lane inputs is a NaN (exponent bits 30:23 all ones and fraction bits 22:0 non-zero), the output lane is the second operand, whether that operand is a NaN or a number.
- R4: A signaling NaN (bit 22 clear) taken from the second operand reaches the output unchanged; bit 22 is not set.
- R5: `vlen_sel` picks the active lanes: 0 gives lanes 0..3 (128 bits), 1 gives lanes 0..7 (256 bits), 2 or 3 gives all 16 lanes (512 bits).
- R6: With `bcast_en`=1, the second operand of every lane is `src_b[31:0]`; with `bcast_en`=0, lane i uses `src_b[32i+31:32i]`.
- R7: With `mask_en`=1 and `zero_mode`=0, an active lane whose `lane_mask` bit is 0 outputs the matching `old_dst` lane.
- R8: With `mask_en`=1 and `zero_mode`=1, an active lane whose `lane_mask` bit is 0 outputs zero.
- R9: With `mask_en`=0, every active lane outputs its maximum, whatever `lane_mask` holds.
- R10: Lanes above the active length output zero when `upper_zero`=1 and the matching `old_dst` lane when `upper_zero`=0.
- R11: `dst` is registered: it changes only at a rising `clk` edge, reflecting the inputs at that edge, and it is all-zero while `rst_n` is low.
- R12: Denormal inputs are ordered by their raw encoding, with no flushing to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 512 | First source vector, 16 lanes of 32 bits |
| src_b | input | 512 | Second source vector; bits 31:0 are the broadcast element |
| bcast_en | input | 1 | Use `src_b[31:0]` as the second operand of every lane |
| old_dst | input | 512 | Previous destination contents for merging and the upper policy |
| lane_mask | input | 16 | Per-lane write enable, bit i for lane i |
| mask_en | input | 1 | Apply `lane_mask`; when 0 all lanes are written |
| zero_mode | input | 1 | Masked-off lanes: 1 zeroes them, 0 keeps `old_dst` |
| vlen_sel | input | 2 | Active length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| upper_zero | input | 1 | Lanes above the active length: 1 zeroes them, 0 keeps `old_dst` |
| dst | output | 512 | Registered result vector |

## Verification
The clocked properties assume the inputs are stable and known at each rising edge. They relate `dst` to the inputs of the previous edge, and they check nothing on an edge that directly follows reset. Lane 0 carries most of them, because lane 0 is active at every length and takes `src_b[31:0]` whether or not broadcast is on. The bench changes its inputs only on the falling edge and holds them across the next rising edge. It builds NaNs and zeros deliberately, and its random numbers are forced away from the all-ones exponent, so each scenario exercises exactly the case it names.

// File: rtl/fpmax_pkg.sv
package fpmax_pkg;
   localparam int ELEM_W  = 32;
   localparam int EXP_W   = 8;
   localparam int FRAC_W  = 23;

   typedef enum logic [1:0] {
      VL_QUARTER = 2'd0,
      VL_HALF    = 2'd1,
      VL_FULL    = 2'd2,
      VL_FULL_X  = 2'd3
   } vlen_e;

   function automatic logic elem_is_nan(input logic [ELEM_W-1:0] x);
      return (&x[ELEM_W-2 -: EXP_W]) && (|x[FRAC_W-1:0]);
   endfunction

   function automatic logic elem_is_zero(input logic [ELEM_W-1:0] x);
      return ~|x[ELEM_W-2:0];
   endfunction
endpackage

// File: rtl/fpmax_lane.sv
module fpmax_lane
   import fpmax_pkg::*;
(
   input  logic [ELEM_W-1:0] op_a,
   input  logic [ELEM_W-1:0] op_b,
   output logic [ELEM_W-1:0] max_o
);
   logic              sign_a, sign_b;
   logic [ELEM_W-2:0] mag_a, mag_b;
   logic              any_nan, both_zero, a_greater, take_a;

   assign sign_a = op_a[ELEM_W-1];
   assign sign_b = op_b[ELEM_W-1];
   assign mag_a  = op_a[ELEM_W-2:0];
   assign mag_b  = op_b[ELEM_W-2:0];

   assign any_nan   = elem_is_nan(op_a) | elem_is_nan(op_b);
   assign both_zero = elem_is_zero(op_a) & elem_is_zero(op_b);

   // sign-magnitude ordering on the raw encoding
   always_comb begin
      if (sign_a != sign_b)
         a_greater = sign_b;
      else if (sign_a)
         a_greater = (mag_a < mag_b);
      else
         a_greater = (mag_a > mag_b);
   end

   assign take_a = ~any_nan & ~both_zero & a_greater;
   assign max_o  = take_a ? op_a : op_b;
endmodule

// File: rtl/fpmax_len_decode.sv
module fpmax_len_decode
   import fpmax_pkg::*;
#(
   parameter int NUM_LANES = 16
) (
   input  logic [1:0]           vlen_sel,
   output logic [NUM_LANES-1:0] active
);
   localparam int CNT_W = $clog2(NUM_LANES + 1);
   localparam logic [CNT_W-1:0] N_QUARTER = CNT_W'(NUM_LANES / 4);
   localparam logic [CNT_W-1:0] N_HALF    = CNT_W'(NUM_LANES / 2);
   localparam logic [CNT_W-1:0] N_FULL    = CNT_W'(NUM_LANES);

   logic [CNT_W-1:0] lane_cnt;

   always_comb begin
      unique case (vlen_e'(vlen_sel))
         VL_QUARTER: lane_cnt = N_QUARTER;
         VL_HALF:    lane_cnt = N_HALF;
         default:    lane_cnt = N_FULL;
      endcase
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_act
      assign active[i] = (CNT_W'(i) < lane_cnt);
   end
endmodule

// File: rtl/fpmax_lane_sel.sv
module fpmax_lane_sel
   import fpmax_pkg::*;
(
   input  logic              active,
   input  logic              write_en,
   input  logic              zero_mode,
   input  logic              upper_zero,
   input  logic [ELEM_W-1:0] max_val,
   input  logic [ELEM_W-1:0] old_val,
   output logic [ELEM_W-1:0] lane_o
);
   always_comb begin
      if (!active)
         lane_o = upper_zero ? '0 : old_val;
      else if (write_en)
         lane_o = max_val;
      else
         lane_o = zero_mode ? '0 : old_val;
   end
endmodule

// File: rtl/fpmax_vec.sv
module fpmax_vec
   import fpmax_pkg::*;
#(
   parameter  int NUM_LANES = 16,
   localparam int VEC_W     = NUM_LANES * ELEM_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [VEC_W-1:0]     src_a,
   input  logic [VEC_W-1:0]     src_b,
   input  logic                 bcast_en,
   input  logic [VEC_W-1:0]     old_dst,
   input  logic [NUM_LANES-1:0] lane_mask,
   input  logic                 mask_en,
   input  logic                 zero_mode,
   input  logic [1:0]           vlen_sel,
   input  logic                 upper_zero,
   output logic [VEC_W-1:0]     dst
);
   if (NUM_LANES < 4 || (NUM_LANES % 4) != 0) begin : g_bad_lanes
      $error("fpmax_vec: NUM_LANES must be a positive multiple of 4");
   end

   logic [NUM_LANES-1:0] active;
   logic [NUM_LANES-1:0] write_en;
   logic [VEC_W-1:0]     next_dst;

   fpmax_len_decode #(.NUM_LANES(NUM_LANES)) u_len (
      .vlen_sel (vlen_sel),
      .active   (active)
   );

   assign write_en = mask_en ? lane_mask : '1;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      logic [ELEM_W-1:0] opb, mx;

      if (i == 0) begin : g_b0
         assign opb = src_b[ELEM_W-1:0];
      end else begin : g_bn
         assign opb = bcast_en ? src_b[ELEM_W-1:0] : src_b[i*ELEM_W +: ELEM_W];
      end

      fpmax_lane u_cmp (
         .op_a  (src_a[i*ELEM_W +: ELEM_W]),
         .op_b  (opb),
         .max_o (mx)
      );

      fpmax_lane_sel u_sel (
         .active     (active[i]),
         .write_en   (write_en[i]),
         .zero_mode  (zero_mode),
         .upper_zero (upper_zero),
         .max_val    (mx),
         .old_val    (old_dst[i*ELEM_W +: ELEM_W]),
         .lane_o     (next_dst[i*ELEM_W +: ELEM_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dst <= '0;
      else
         dst <= next_dst;
   end
endmodule

// File: rtl/fpmax_vec_chk.sv
module fpmax_vec_chk
   import fpmax_pkg::*;
#(
   parameter  int NUM_LANES = 16,
   localparam int VEC_W     = NUM_LANES * ELEM_W,
   localparam int LOW_W     = (NUM_LANES / 4) * ELEM_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [VEC_W-1:0]     src_a,
   input logic [VEC_W-1:0]     src_b,
   input logic                 bcast_en,
   input logic [VEC_W-1:0]     old_dst,
   input logic [NUM_LANES-1:0] lane_mask,
   input logic                 mask_en,
   input logic                 zero_mode,
   input logic [1:0]           vlen_sel,
   input logic                 upper_zero,
   input logic [VEC_W-1:0]     dst
);
   logic [ELEM_W-1:0] a0, b0, b1;
   logic              wr0, a0_nan, b0_nan;

   assign a0     = src_a[ELEM_W-1:0];
   assign b0     = src_b[ELEM_W-1:0];
   assign b1     = src_b[2*ELEM_W-1:ELEM_W];
   assign wr0    = !mask_en || lane_mask[0];
   assign a0_nan = (a0[30:23] == 8'hFF) && (a0[22:0] != 23'd0);
   assign b0_nan = (b0[30:23] == 8'hFF) && (b0[22:0] != 23'd0);

   // R1
   pos_over_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr0 && !a0[31] && b0[31] && !a0_nan && !b0_nan
                             && (a0[30:0] != 31'd0 || b0[30:0] != 31'd0)))
      |-> dst[ELEM_W-1:0] == $past(a0));

   // R2
   zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr0 && a0[30:0] == 31'd0 && b0[30:0] == 31'd0))
      |-> dst[ELEM_W-1:0] == $past(b0));

   // R3
   nan_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr0 && (a0_nan || b0_nan)))
      |-> dst[ELEM_W-1:0] == $past(b0));

   // R6
   bcast_lane1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bcast_en && !mask_en && vlen_sel != 2'd0 && b0_nan))
      |-> dst[2*ELEM_W-1:ELEM_W] == $past(b0));

   // R6
   nobcast_lane1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!bcast_en && !mask_en && vlen_sel != 2'd0
                             && (b1[30:23] == 8'hFF) && (b1[22:0] != 23'd0)))
      |-> dst[2*ELEM_W-1:ELEM_W] == $past(b1));

   // R7
   merge_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mask_en && !lane_mask[0] && !zero_mode))
      |-> dst[ELEM_W-1:0] == $past(old_dst[ELEM_W-1:0]));

   // R8
   zeroing_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mask_en && !lane_mask[0] && zero_mode))
      |-> dst[ELEM_W-1:0] == '0);

   // R10
   upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(vlen_sel == 2'd0 && upper_zero))
      |-> dst[VEC_W-1:LOW_W] == '0);

   // R10
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(vlen_sel == 2'd0 && !upper_zero))
      |-> dst[VEC_W-1:LOW_W] == $past(old_dst[VEC_W-1:LOW_W]));
endmodule

bind fpmax_vec fpmax_vec_chk #(.NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/fpmax_vec_test.sv
`timescale 1ns/1ps
module fpmax_vec_test;
   localparam int L = 16;
   localparam int W = L * 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_v = '0, b_v = '0, old_v = '0;
   logic         bcast = 1'b0, men = 1'b0, zm = 1'b0, uz = 1'b1;
   logic [L-1:0] msk = '1;
   logic [1:0]   vl = 2'd2;
   logic [W-1:0] dst;

   int nvec = 0;
   int nmis = 0;
   int cyc  = 0;

   always #4 clk = ~clk;

   fpmax_vec uut (
      .clk(clk), .rst_n(rst_n), .src_a(a_v), .src_b(b_v), .bcast_en(bcast),
      .old_dst(old_v), .lane_mask(msk), .mask_en(men), .zero_mode(zm),
      .vlen_sel(vl), .upper_zero(uz), .dst(dst)
   );

   function automatic logic fnan(input logic [31:0] x);
      return x[30:23] == 8'hFF && x[22:0] != 0;
   endfunction

   // monotone key: unsigned order of key matches numeric order
   function automatic logic [31:0] fkey(input logic [31:0] x);
      return x[31] ? ~x : (x | 32'h8000_0000);
   endfunction

   function automatic logic [31:0] ref_max(input logic [31:0] a, input logic [31:0] b);
      if (fnan(a) || fnan(b)) return b;
      if (a[30:0] == 0 && b[30:0] == 0) return b;
      return (fkey(a) > fkey(b)) ? a : b;
   endfunction

   function automatic logic [W-1:0] ref_vec();
      logic [W-1:0] r;
      int n;
      n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
      for (int i = 0; i < L; i++) begin
         logic [31:0] bb, oo;
         bb = bcast ? b_v[31:0] : b_v[i*32 +: 32];
         oo = old_v[i*32 +: 32];
         if (i >= n)
            r[i*32 +: 32] = uz ? 32'd0 : oo;
         else if (!men || msk[i])
            r[i*32 +: 32] = ref_max(a_v[i*32 +: 32], bb);
         else
            r[i*32 +: 32] = zm ? 32'd0 : oo;
      end
      return r;
   endfunction

   function automatic logic [31:0] rnum();
      logic [31:0] x;
      x = $urandom;
      if (x[30:23] == 8'hFF) x[30] = 1'b0;
      return x;
   endfunction

   task automatic compare(input string req, input logic [W-1:0] exp_v);
      nvec++;
      if (dst !== exp_v) begin
         nmis++;
         $display("FAIL %s: dst=%h expected=%h", req, dst, exp_v);
      end
   endtask

   task automatic run(input string req);
      logic [W-1:0] e;
      e = ref_vec();
      @(posedge clk);
      #2;
      compare(req, e);
   endtask

   task automatic defaults();
      @(negedge clk);
      bcast = 0; men = 0; zm = 0; uz = 1; msk = '1; vl = 2'd2;
      for (int i = 0; i < L; i++) old_v[i*32 +: 32] = $urandom;
   endtask

   task automatic t_reset();
      #1;
      compare("R11 reset", '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_ordinary();
      for (int k = 0; k < 6; k++) begin
         defaults();
         for (int i = 0; i < L; i++) begin
            a_v[i*32 +: 32] = rnum();
            b_v[i*32 +: 32] = rnum();
         end
         run("R1 random lanes");
      end
   endtask

   task automatic t_signs();
      defaults();
      a_v = '0; b_v = '0;
      a_v[0*32 +: 32] = 32'hC040_0000; b_v[0*32 +: 32] = 32'hC0A0_0000; // -3 vs -5
      a_v[1*32 +: 32] = 32'hC0A0_0000; b_v[1*32 +: 32] = 32'hC040_0000;
      a_v[2*32 +: 32] = 32'h3F80_0000; b_v[2*32 +: 32] = 32'hBF80_0000;
      a_v[3*32 +: 32] = 32'hBF80_0000; b_v[3*32 +: 32] = 32'h3F80_0000;
      a_v[4*32 +: 32] = 32'h4000_0000; b_v[4*32 +: 32] = 32'h4000_0000;
      a_v[5*32 +: 32] = 32'h8000_0000; b_v[5*32 +: 32] = 32'hBF80_0000; // -0 vs -1
      a_v[6*32 +: 32] = 32'h7F80_0000; b_v[6*32 +: 32] = 32'h7F7F_FFFF; // inf vs max
      a_v[7*32 +: 32] = 32'hFF80_0000; b_v[7*32 +: 32] = 32'hFF7F_FFFF;
      run("R1 sign and magnitude ordering");
   endtask

   task automatic t_zeros();
      defaults();
      a_v = '0; b_v = '0;
      for (int i = 0; i < L; i++) begin
         a_v[i*32+31] = i[0];
         b_v[i*32+31] = i[1];
      end
      run("R2 zero pairs");
   endtask

   task automatic t_nan();
      defaults();
      for (int i = 0; i < L; i++) begin
         a_v[i*32 +: 32] = rnum();
         b_v[i*32 +: 32] = rnum();
      end
      a_v[0*32 +: 32] = 32'h7FC0_0001;
      b_v[1*32 +: 32] = 32'hFFC1_2345;
      a_v[2*32 +: 32] = 32'h7FC0_0003; b_v[2*32 +: 32] = 32'hFFE0_0000;
      a_v[3*32 +: 32] = 32'h7F80_0055;
      run("R3 NaN in either operand");
   endtask

   task automatic t_snan();
      defaults();
      for (int i = 0; i < L; i++) begin
         a_v[i*32 +: 32] = rnum();
         b_v[i*32 +: 32] = 32'h7F80_0001 + i;
      end
      b_v[15*32 +: 32] = 32'hFFA0_0000;
      run("R4 signaling NaN from second operand");
   endtask

   task automatic t_vlen();
      for (int s = 0; s < 4; s++) begin
         defaults();
         vl = s[1:0];
         for (int i = 0; i < L; i++) begin
            a_v[i*32 +: 32] = rnum();
            b_v[i*32 +: 32] = rnum();
         end
         run("R5 active length");
      end
   endtask

   task automatic t_bcast();
      for (int s = 1; s < 3; s++) begin
         defaults();
         bcast = 1; vl = s[1:0];
         for (int i = 0; i < L; i++) begin
            a_v[i*32 +: 32] = rnum();
            b_v[i*32 +: 32] = rnum();
         end
         run("R6 broadcast element");
      end
      defaults();
      bcast = 1;
      b_v[31:0] = 32'h7F80_0007;
      run("R6 broadcast signaling NaN");
   endtask

   task automatic t_mask(input logic zmode, input string req);
      defaults();
      men = 1; zm = zmode; msk = 16'hA5C3;
      for (int i = 0; i < L; i++) begin
         a_v[i*32 +: 32] = rnum();
         b_v[i*32 +: 32] = rnum();
      end
      run(req);
   endtask

   task automatic t_nomask();
      defaults();
      men = 0; zm = 1; msk = '0;
      for (int i = 0; i < L; i++) begin
         a_v[i*32 +: 32] = rnum();
         b_v[i*32 +: 32] = rnum();
      end
      run("R9 mask disabled");
   endtask

   task automatic t_upper();
      for (int s = 0; s < 2; s++) begin
         defaults();
         uz = 0; vl = s[1:0]; men = 1; zm = 1; msk = 16'h0F0A;
         for (int i = 0; i < L; i++) begin
            a_v[i*32 +: 32] = rnum();
            b_v[i*32 +: 32] = rnum();
         end
         run("R10 preserve upper");
      end
   endtask

   task automatic t_denorm();
      defaults();
      for (int i = 0; i < L; i++) begin
         a_v[i*32 +: 32] = {i[0], 8'h00, 23'($urandom)};
         b_v[i*32 +: 32] = {i[1], 8'h00, 23'($urandom)};
      end
      a_v[0*32 +: 32] = 32'h0000_0002; b_v[0*32 +: 32] = 32'h0000_0001;
      a_v[1*32 +: 32] = 32'h8000_0001; b_v[1*32 +: 32] = 32'h0000_0000;
      run("R12 denormal ordering");
   endtask

   task automatic t_latency();
      logic [W-1:0] held;
      defaults();
      held = dst;
      for (int i = 0; i < L; i++) begin
         a_v[i*32 +: 32] = rnum();
         b_v[i*32 +: 32] = rnum();
      end
      #1;
      compare("R11 output holds until clock edge", held);
      run("R11 output after one edge");
   endtask

   initial begin
      t_reset();
      t_ordinary();
      t_signs();
      t_zeros();
      t_nan();
      t_snan();
      t_vlen();
      t_bcast();
      t_mask(1'b0, "R7 merge masking");
      t_mask(1'b1, "R8 zeroing masking");
      t_nomask();
      t_upper();
      t_denorm();
      t_latency();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         nmis++;
         $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
         $finish;
      end
   end
endmodule